// File: doc/BRIEF.md
# Multiplexed Address Bus Sequencer

This block carries a 16-bit memory address over an 8-bit address port in two phases. When a memory cycle starts, it captures the address from the processor core and drives the upper byte onto the pins. It then raises a one-clock strobe so that external logic can catch the upper bits, and after that it drives the lower byte for the rest of the cycle. Each memory cycle lasts `CYC_LEN` clocks, 8 by default. The upper byte is driven in clocks 0 and 1, the strobe is high in clock 1, and the lower byte is driven from clock 2 to clock 7.

A companion demultiplex latch sits on the pin side. It keeps the lowest `UPPER_BITS` bits of the upper byte, taken on the strobe, and joins them with the lower byte that is still on the pins. The result is a rebuilt address for a memory of configurable size. For example, `UPPER_BITS = 4` gives a 12-bit address for a 4K-byte memory. The block holds all of its progress in flip-flops, so the clock may stop and restart in the middle of a cycle without loss.

The control is a four-state machine. `ST_IDLE` waits for a start. `ST_HIGH` drives the upper byte before the strobe. `ST_STROBE` drives the upper byte with the strobe raised. `ST_LOW` drives the lower byte until the last clock of the cycle. The transitions are:
- IDLE→HIGH when start is sampled.
- HIGH→STROBE when the pre-strobe clocks are done.
- STROBE→LOW always.
- LOW→HIGH when start is sampled in the last clock (a back-to-back cycle).
- LOW→IDLE when the last clock ends with no start.

Top module: `addr_mux_seq`

## Requirements
- R1: After reset, and whenever no cycle is running, `addr_pins` is 0, `upper_strobe` is 0, `full_addr_valid` is 0 and `full_addr` is 0.
- R2: When `cyc_start` is high at a rising edge while idle, the next two clocks (cycle clocks 0 and 1) drive `core_addr[15:8]` as it was at that edge onto `addr_pins`.
- R3: `upper_strobe` is high in cycle clock 1 only, exactly one clock per cycle.
- R4: In cycle clocks 2 to 7, `addr_pins` holds the captured `core_addr[7:0]` without change.
- R5: While `full_addr_valid` is high, `full_addr[7:0]` equals the lower byte. `full_addr[UPPER_BITS+7:8]` equals the lowest `UPPER_BITS` bits of the captured upper byte, and every bit above them is 0 (default `UPPER_BITS` = 4).
- R6: `full_addr_valid` is high in cycle clocks 2 to 7 only.
- R7: `cyc_start` in cycle clocks 0 to 6, and any change of `core_addr` after the start edge, have no effect on the running cycle.
- R8: `cyc_start` high in cycle clock 7 starts a new cycle in the next clock, with no idle clock between them.
- R9: Stopping the clock in any cycle clock and restarting it keeps all outputs unchanged while stopped, and the sequence resumes where it left off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single-phase clock, may be stopped |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | Request to begin a memory cycle |
| core_addr | input | 16 | Address from the processor core |
| addr_pins | output | 8 | Multiplexed address pins |
| upper_strobe | output | 1 | Pulse for capturing the upper byte |
| full_addr | output | 16 | Rebuilt address, upper unused bits zero |
| full_addr_valid | output | 1 | Rebuilt address is valid |

## Verification
The hardest situations to reach from the ports are a new start that lands exactly in the last clock of a cycle, and a clock that halts in the middle of a sequence. The stimulus draws random addresses from a fixed seed and randomly chains cycles back to back through a start in clock 7. In random cycles it also gates the bench clock off for several periods at a randomly chosen cycle clock, and compares the outputs before, during and after the pause. Every cycle also raises a spurious start in clock 3 and scrambles `core_addr` right after the start edge, to show that both are ignored.

// File: rtl/amux_pkg.sv
package amux_pkg;

    localparam int PIN_W  = 8;
    localparam int ADDR_W = 2 * PIN_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HIGH   = 2'd1,
        ST_STROBE = 2'd2,
        ST_LOW    = 2'd3
    } seq_state_t;

endpackage

// File: rtl/amux_seq_fsm.sv
module amux_seq_fsm
    import amux_pkg::*;
#(
    parameter int CYC_LEN = 8,
    parameter int HI_LEN  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output seq_state_t state,
    output logic       load
);

    localparam int CNT_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_PRE_STROBE = CNT_W'(HI_LEN - 2);
    localparam logic [CNT_W-1:0] CNT_LAST       = CNT_W'(CYC_LEN - 1);

    seq_state_t       state_nxt;
    logic [CNT_W-1:0] cnt;

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   state_nxt = start ? ST_HIGH : ST_IDLE;
            ST_HIGH:   state_nxt = (cnt == CNT_PRE_STROBE) ? ST_STROBE : ST_HIGH;
            ST_STROBE: state_nxt = ST_LOW;
            ST_LOW: begin
                if (cnt == CNT_LAST) state_nxt = start ? ST_HIGH : ST_IDLE;
                else                 state_nxt = ST_LOW;
            end
            default:   state_nxt = ST_IDLE;
        endcase
    end

    assign load = (state_nxt == ST_HIGH) && (state != ST_HIGH);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // position within the cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (load)             cnt <= '0;
        else if (state != ST_IDLE) cnt <= cnt + CNT_W'(1);
    end

    // R6: the counter never runs past the cycle length
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);

    // R3: the strobe state is entered only from the upper-byte state
    p_strobe_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE) |-> ($past(state) == ST_HIGH));

    // R8: the lower-byte state ends only on the last cycle clock
    p_low_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_LOW && state != ST_LOW) |-> ($past(cnt) == CNT_LAST));

endmodule

// File: rtl/amux_pin_drv.sv
module amux_pin_drv
    import amux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] core_addr,
    input  seq_state_t        state,
    output logic [PIN_W-1:0]  addr_pins,
    output logic              upper_strobe,
    output logic              low_phase
);

    logic [ADDR_W-1:0] addr_q;

    // address captured at the start edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= core_addr;
    end

    // pin outputs decoded from the state
    always_comb begin
        addr_pins    = '0;
        upper_strobe = 1'b0;
        low_phase    = 1'b0;
        unique case (state)
            ST_IDLE:   addr_pins = '0;
            ST_HIGH:   addr_pins = addr_q[ADDR_W-1:PIN_W];
            ST_STROBE: begin
                addr_pins    = addr_q[ADDR_W-1:PIN_W];
                upper_strobe = 1'b1;
            end
            ST_LOW: begin
                addr_pins = addr_q[PIN_W-1:0];
                low_phase = 1'b1;
            end
            default:   addr_pins = '0;
        endcase
    end

    // R3: the upper byte stays put across the strobe clock
    p_strobe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upper_strobe |-> $stable(addr_pins));

    // R3: the strobe lasts a single clock
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upper_strobe |=> !upper_strobe);

    // R4: the lower byte does not move during the low phase
    p_low_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (low_phase && $past(low_phase)) |-> $stable(addr_pins));

    // R1: idle pins are quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (addr_pins == '0 && !upper_strobe));

endmodule

// File: rtl/amux_demux_latch.sv
module amux_demux_latch
    import amux_pkg::*;
#(
    parameter int UPPER_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pins,
    input  logic              strobe,
    input  logic              low_phase,
    output logic [ADDR_W-1:0] rebuilt,
    output logic              rebuilt_valid
);

    localparam logic [ADDR_W-1:0] USED_MASK =
        ADDR_W'((32'd1 << (UPPER_BITS + PIN_W)) - 32'd1);

    logic [ADDR_W-1:0] joined;

    generate
        if (UPPER_BITS == 0) begin : g_no_upper
            assign joined = {{PIN_W{1'b0}}, pins};
        end else begin : g_upper
            logic [UPPER_BITS-1:0] upper_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      upper_q <= '0;
                else if (strobe) upper_q <= pins[UPPER_BITS-1:0];
            end
            if (UPPER_BITS == PIN_W) begin : g_full
                assign joined = {upper_q, pins};
            end else begin : g_part
                assign joined = {{(PIN_W-UPPER_BITS){1'b0}}, upper_q, pins};
            end
        end
    endgenerate

    assign rebuilt_valid = low_phase;
    assign rebuilt       = low_phase ? joined : '0;

    // R5: unused upper bits always read zero
    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rebuilt & ~USED_MASK) == '0);

    // R5: the low byte of the rebuilt address follows the pins
    p_low_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rebuilt_valid |-> (rebuilt[PIN_W-1:0] == pins));

    // R6: validity begins right after the strobe
    p_valid_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> rebuilt_valid);

endmodule

// File: rtl/addr_mux_seq.sv
module addr_mux_seq
    import amux_pkg::*;
#(
    parameter int CYC_LEN    = 8,
    parameter int HI_LEN     = 2,
    parameter int UPPER_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cyc_start,
    input  logic [15:0] core_addr,
    output logic [7:0]  addr_pins,
    output logic        upper_strobe,
    output logic [15:0] full_addr,
    output logic        full_addr_valid
);

    seq_state_t state;
    logic       load;
    logic       low_phase;

    amux_seq_fsm #(
        .CYC_LEN (CYC_LEN),
        .HI_LEN  (HI_LEN)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cyc_start),
        .state (state),
        .load  (load)
    );

    amux_pin_drv u_drv (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .core_addr    (core_addr),
        .state        (state),
        .addr_pins    (addr_pins),
        .upper_strobe (upper_strobe),
        .low_phase    (low_phase)
    );

    amux_demux_latch #(
        .UPPER_BITS (UPPER_BITS)
    ) u_latch (
        .clk           (clk),
        .rst_n         (rst_n),
        .pins          (addr_pins),
        .strobe        (upper_strobe),
        .low_phase     (low_phase),
        .rebuilt       (full_addr),
        .rebuilt_valid (full_addr_valid)
    );

    // R1: nothing is valid outside a cycle
    p_invalid_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !full_addr_valid |-> (full_addr == '0));

    // R3: strobe and valid never overlap
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(upper_strobe && full_addr_valid));

endmodule

// File: tb/test_addr_mux_seq.sv
`timescale 1ns/1ps
module test_addr_mux_seq;

    localparam int UB = 4;

    logic        clk = 1'b0;
    logic        clk_run = 1'b1;
    logic        rst_n = 1'b0;
    logic        cyc_start = 1'b0;
    logic [15:0] core_addr = '0;
    logic [7:0]  addr_pins;
    logic        upper_strobe;
    logic [15:0] full_addr;
    logic        full_addr_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 if (clk_run) clk = ~clk;

    addr_mux_seq #(.UPPER_BITS(UB)) i_addr_mux_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .cyc_start       (cyc_start),
        .core_addr       (core_addr),
        .addr_pins       (addr_pins),
        .upper_strobe    (upper_strobe),
        .full_addr       (full_addr),
        .full_addr_valid (full_addr_valid)
    );

    function automatic logic [7:0] exp_pins(logic [15:0] a, int k);
        return (k < 2) ? a[15:8] : a[7:0];
    endfunction

    function automatic logic exp_strobe(int k);
        return k == 1;
    endfunction

    function automatic logic exp_valid(int k);
        return k >= 2;
    endfunction

    function automatic logic [15:0] exp_full(logic [15:0] a, int k);
        logic [15:0] up;
        if (k < 2) return 16'h0;
        up = (16'(a[15:8]) & 16'((1 << UB) - 1)) << 8;
        return up | 16'(a[7:0]);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_clock(logic [15:0] a, int k, string tag);
        check({tag, " R2/R4 pins"}, 32'(addr_pins), 32'(exp_pins(a, k)));
        check({tag, " R3 strobe"}, 32'(upper_strobe), 32'(exp_strobe(k)));
        check({tag, " R6 valid"}, 32'(full_addr_valid), 32'(exp_valid(k)));
        check({tag, " R5 full_addr"}, 32'(full_addr), 32'(exp_full(a, k)));
    endtask

    task automatic check_idle(string tag);
        check({tag, " R1 pins"}, 32'(addr_pins), 32'h0);
        check({tag, " R1 strobe"}, 32'(upper_strobe), 32'h0);
        check({tag, " R1 valid"}, 32'(full_addr_valid), 32'h0);
        check({tag, " R1 full_addr"}, 32'(full_addr), 32'h0);
    endtask

    // Runs one cycle whose start is already driven; optionally chains the next.
    task automatic run_cycle(logic [15:0] a, bit chain, logic [15:0] nxt, int pause_at);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (k == 0) begin
                cyc_start = 1'b0;
                core_addr = 16'($urandom);   // R7: late address change ignored
            end
            if (k == 3) cyc_start = 1'b1;    // R7: spurious start mid-cycle
            if (k == 4) cyc_start = 1'b0;
            check_clock(a, k, "R7 cycle");
            if (k == pause_at) begin
                clk_run = 1'b0;
                #40;
                check_clock(a, k, "R9 paused");
                clk_run = 1'b1;
            end
            if (k == 7) begin
                cyc_start = chain;           // R8: start in last clock
                core_addr = nxt;
            end
        end
        if (!chain) begin
            @(negedge clk);
            check_idle("R7 after");
        end
    endtask

    task automatic begin_cycle(logic [15:0] a);
        @(negedge clk);
        cyc_start = 1'b1;
        core_addr = a;
    endtask

    initial begin
        logic [15:0] cur;
        logic [15:0] nxt;
        bit          chain;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 released");

        // directed corner cases
        begin_cycle(16'hFFFF);
        run_cycle(16'hFFFF, 1'b0, 16'h0, -1);
        begin_cycle(16'h0000);
        run_cycle(16'h0000, 1'b1, 16'hA55A, -1);
        run_cycle(16'hA55A, 1'b1, 16'h3C96, 1);   // R8 chained, R9 pause on strobe
        run_cycle(16'h3C96, 1'b0, 16'h0, 7);      // R9 pause in last clock

        // random stimulus
        cur = 16'($urandom);
        begin_cycle(cur);
        for (int i = 0; i < 60; i++) begin
            chain = ($urandom % 2) == 0;
            nxt   = 16'($urandom);
            run_cycle(cur, chain, nxt, (($urandom % 3) == 0) ? int'($urandom % 8) : -1);
            if (!chain) begin
                repeat ($urandom % 3) begin
                    @(negedge clk);
                    check_idle("R1 gap");
                end
                begin_cycle(nxt);
            end
            cur = nxt;
        end
        run_cycle(cur, 1'b0, 16'h0, -1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule